// File: doc/BRIEF.md
# Sinusoid DDS Waveform Generator

This block synthesizes a digital sine wave for a DAC. Software sets four registers through a plain write/read port: a frequency step, a phase offset, a signed output offset and an unsigned amplitude. Raising `run_en` copies all four into a working set. From then on a 30-bit phase accumulator advances by the frequency step, and the phase offset is added to the top 20 phase bits. A quarter-wave table, mirrored by quadrant, turns the result into a signed sine value. That value is scaled by the amplitude, shifted by the offset and clamped to a 12-bit signed DAC code.

Samples leave on a valid/ready stream. A sample is transferred on a clock where both `smp_valid` and `smp_ready` are high. While a valid sample waits with `smp_ready` low, `smp_data` holds its value and the whole pipeline stalls, the accumulator included. No sample is lost or repeated, and the output frequency is measured in accepted samples. Lowering `run_en` ends the stream at once and discards any sample in flight; this is the one case where valid may fall without a transfer.

Top module: `sine_dds_gen`

## Requirements
- R1: Register map on `cfg_addr`: 0 is the frequency step (30 bits), 1 is the phase offset (20 bits), 2 is the output offset (12-bit two's complement) and 3 is the amplitude (11 bits unsigned). All four reset to zero. A write keeps only the low field bits, and `cfg_rdata` returns the field zero-extended to 32 bits.
- R2: Accepted sample k (counting from 0 after each enable) uses accumulator phase A = (k × step) mod 2^30. Each enable restarts A from zero.
- R3: The table phase is P = (A[29:10] + phase offset) mod 2^20, so a phase offset of 0x20000 shifts the wave by 45°.
- R4: With quadrant q = P[19:18] and j = P[17:12], let T(i) = floor(2047·sin(π(i+0.5)/128) + 0.5) for i in 0..63. The sine value s is +T(j) for q=0, +T(63−j) for q=1, −T(j) for q=2 and −T(63−j) for q=3.
- R5: The pre-clamp value is floor(s × amplitude / 2048) + offset.
- R6: The output is clamped to the range −2048..2047 and never wraps.
- R7: All four settings are captured on the clock where `run_en` is first seen high. Register writes made while running do not change the running waveform.
- R8: On back-to-back ready, `smp_valid` first rises on the third clock after the capture clock, and after that a new sample is presented on every clock.
- R9: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high and `smp_data` holds its value.
- R10: When `run_en` is low, `smp_valid` falls on the next clock. Whenever no valid sample is presented, `smp_data` shows the currently configured output offset.
- R11: A step of zero yields a constant stream equal to the R4/R5/R6 value at phase P = phase offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| run_en | input | 1 | Generation enable |
| smp_ready | input | 1 | Downstream ready |
| smp_valid | output | 1 | Sample valid |
| smp_data | output | 12 | Signed DAC sample |

## Verification
The stream is driven with several step values: an irregular step that visits every table index and quadrant, a step of all ones that makes the phase run backwards through the modulus, and a step of zero. Together these separate errors in accumulation and wrap from errors in the table mirror. Separate runs use a 45° phase offset, zero and mid-range amplitudes, and offsets large enough to saturate at both rails, which isolates the offset adder, the scaler rounding and the clamp. One run uses random back-pressure to show that stalls neither drop nor repeat samples. Another writes every register mid-run and then re-enables, which shows that captured settings are frozen and that the phase restarts from zero.

// File: rtl/sdds_pkg.sv
package sdds_pkg;
  localparam int ACC_W  = 30;
  localparam int PH_W   = 20;
  localparam int LUT_AW = 6;
  localparam int DW     = 12;
  localparam int AMP_W  = 11;
  localparam int OFF_W  = 12;
  localparam int REG_W  = 32;

  typedef enum logic [1:0] {
    A_STEP  = 2'd0,
    A_PHASE = 2'd1,
    A_OFFS  = 2'd2,
    A_AMP   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [ACC_W-1:0]        step;
    logic [PH_W-1:0]         phase;
    logic signed [OFF_W-1:0] offs;
    logic [AMP_W-1:0]        amp;
  } wave_cfg_t;
endpackage

// File: rtl/sdds_cfg_regs.sv
module sdds_cfg_regs
  import sdds_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  input  logic          capture,
  input  logic          running,
  output wave_cfg_t     live,
  output wave_cfg_t     snap
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[RW-1:ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      snap <= '0;
    end else begin
      if (capture) snap <= live;
      if (wr_en) begin
        case (reg_addr_e'(addr))
          A_STEP:  live.step  <= wdata[ACC_W-1:0];
          A_PHASE: live.phase <= wdata[PH_W-1:0];
          A_OFFS:  live.offs  <= wdata[OFF_W-1:0];
          A_AMP:   live.amp   <= wdata[AMP_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_e'(addr))
      A_STEP:  rdata = {{(RW-ACC_W){1'b0}}, live.step};
      A_PHASE: rdata = {{(RW-PH_W){1'b0}}, live.phase};
      A_OFFS:  rdata = {{(RW-OFF_W){1'b0}}, live.offs};
      default: rdata = {{(RW-AMP_W){1'b0}}, live.amp};
    endcase
  end

  // R7: captured settings stay frozen for the whole run
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(snap));
endmodule

// File: rtl/sdds_phase_gen.sv
module sdds_phase_gen
  import sdds_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int PW = PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          adv,
  input  logic [AW-1:0] step,
  input  logic [PW-1:0] phase_off,
  output logic          capture,
  output logic          running,
  output logic [PW-1:0] ph,
  output logic          ph_vld
);
  logic [AW-1:0] acc;

  assign capture = run_en && !running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      acc     <= '0;
      ph      <= '0;
      ph_vld  <= 1'b0;
    end else if (!run_en) begin
      running <= 1'b0;
      acc     <= '0;
      ph_vld  <= 1'b0;
    end else if (capture) begin
      running <= 1'b1;
      acc     <= '0;
      ph_vld  <= 1'b0;
    end else if (adv) begin
      acc    <= acc + step;
      ph     <= acc[AW-1 -: PW] + phase_off;
      ph_vld <= 1'b1;
    end
  end

  // R2: every enable starts the accumulator from zero
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !running) |=> (running && acc == '0));
endmodule

// File: rtl/sdds_sine_lut.sv
module sdds_sine_lut
  import sdds_pkg::*;
#(
  parameter int PW = PH_W,
  parameter int LA = LUT_AW,
  parameter int W  = DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                flush,
  input  logic [PW-1:0]       ph_in,
  input  logic                v_in,
  output logic signed [W-1:0] sine,
  output logic                v_out
);
  localparam int QN   = 1 << LA;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int LOW  = PW - 2 - LA;

  function automatic int quarter_val(int j);
    real ang;
    ang = 3.14159265358979 * (real'(j) + 0.5) / (2.0 * real'(QN));
    return $rtoi(real'(SMAX) * $sin(ang) + 0.5);
  endfunction

  logic [W-2:0] tbl [QN];
  for (genvar i = 0; i < QN; i++) begin : g_tbl
    localparam int VAL = quarter_val(i);
    assign tbl[i] = VAL[W-2:0];
  end

  logic [1:0]          quad;
  logic [LA-1:0]       idx, midx;
  logic signed [W-1:0] mag, val;
  logic                unused_low;

  assign unused_low = ^ph_in[LOW-1:0];
  assign quad = ph_in[PW-1 -: 2];
  assign idx  = ph_in[PW-3 -: LA];
  assign midx = quad[0] ? ~idx : idx;
  assign mag  = {1'b0, tbl[midx]};
  assign val  = quad[1] ? -mag : mag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sine  <= '0;
      v_out <= 1'b0;
    end else if (flush) begin
      v_out <= 1'b0;
    end else if (adv) begin
      sine  <= val;
      v_out <= v_in;
    end
  end
endmodule

// File: rtl/sdds_scale_sat.sv
module sdds_scale_sat
  import sdds_pkg::*;
#(
  parameter int W  = DW,
  parameter int AM = AMP_W,
  parameter int OW = OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 flush,
  input  logic signed [W-1:0]  sine,
  input  logic                 v_in,
  input  logic [AM-1:0]        amp,
  input  logic signed [OW-1:0] offs,
  output logic signed [W-1:0]  dout,
  output logic                 v_out
);
  localparam int PRW  = W + AM + 1;
  localparam int SW   = PRW + 1;
  localparam int MAXV = (1 << (W - 1)) - 1;
  localparam int MINV = -(1 << (W - 1));

  logic signed [PRW-1:0] prod, scaled;
  logic signed [SW-1:0]  sum;
  logic signed [W-1:0]   sat;

  assign prod   = PRW'(sine) * $signed({1'b0, amp});
  assign scaled = prod >>> AM;
  assign sum    = SW'(scaled) + SW'(offs);

  always_comb begin
    if (sum > SW'(MAXV))      sat = W'(MAXV);
    else if (sum < SW'(MINV)) sat = W'(MINV);
    else                      sat = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= '0;
      v_out <= 1'b0;
    end else if (flush) begin
      v_out <= 1'b0;
    end else if (adv) begin
      dout  <= sat;
      v_out <= v_in;
    end
  end

  // R5: zero amplitude leaves only the offset on the output
  p_zero_amp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (v_out && amp == '0) |-> (dout == W'(offs)));
endmodule

// File: rtl/sine_dds_gen.sv
module sine_dds_gen
  import sdds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             run_en,
  input  logic             smp_ready,
  output logic             smp_valid,
  output logic [DW-1:0]    smp_data
);
  wave_cfg_t            live, snap;
  logic                 capture, running, adv, flush;
  logic [PH_W-1:0]      ph;
  logic                 ph_vld, sin_vld;
  logic signed [DW-1:0] sine, dout;

  assign adv   = !(smp_valid && !smp_ready);
  assign flush = !run_en;

  sdds_cfg_regs #(.RW(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .capture(capture),
    .running(running), .live(live), .snap(snap)
  );

  sdds_phase_gen #(.AW(ACC_W), .PW(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .adv(adv),
    .step(snap.step), .phase_off(snap.phase), .capture(capture),
    .running(running), .ph(ph), .ph_vld(ph_vld)
  );

  sdds_sine_lut #(.PW(PH_W), .LA(LUT_AW), .W(DW)) u_lut (
    .clk(clk), .rst_n(rst_n), .adv(adv), .flush(flush),
    .ph_in(ph), .v_in(ph_vld), .sine(sine), .v_out(sin_vld)
  );

  sdds_scale_sat #(.W(DW), .AM(AMP_W), .OW(OFF_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .adv(adv), .flush(flush),
    .sine(sine), .v_in(sin_vld), .amp(snap.amp), .offs(snap.offs),
    .dout(dout), .v_out(smp_valid)
  );

  assign smp_data = smp_valid ? dout : DW'(live.offs);

  // R9: a stalled sample stays valid and unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && run_en) |=> (smp_valid && $stable(smp_data)));

  // R10: dropping the enable ends the stream on the next clock
  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !smp_valid);
endmodule

// File: tb/sine_dds_gen_bench.sv
module sine_dds_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        run_en = 1'b0;
  logic        smp_ready = 1'b1;
  logic        smp_valid;
  logic [11:0] smp_data;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit bp_mode = 1'b0;

  // behavioural reference state
  int  m_step = 0, m_phase = 0, m_offs = 0, m_amp = 0;
  int  s_step = 0, s_phase = 0, s_offs = 0, s_amp = 0;
  bit  m_run = 0;
  int  m_fill = 0;
  longint m_k = 0;

  always #5 clk = ~clk;

  sine_dds_gen u_sine_dds_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .run_en(run_en),
    .smp_ready(smp_ready), .smp_valid(smp_valid), .smp_data(smp_data)
  );

  function automatic int sx12(int v);
    return (v & 12'h800) ? (v & 12'hFFF) - 4096 : (v & 12'hFFF);
  endfunction

  function automatic int tq(int i);
    return $rtoi(2047.0 * $sin(3.14159265358979 * (real'(i) + 0.5) / 128.0) + 0.5);
  endfunction

  function automatic int exp_sample(longint k, int st, int po, int of, int am);
    longint a, pr, sc, v;
    int p, q, j, s;
    a = (k * longint'(st)) % (64'sd1 << 30);
    p = int'(((a >> 10) + po) & 20'hFFFFF);
    q = p >> 18;
    j = (p >> 12) & 63;
    if (q[0]) j = 63 - j;
    s = tq(j);
    if (q[1]) s = -s;
    pr = longint'(s) * am;
    sc = pr >>> 11;
    v = sc + sx12(of);
    if (v > 2047) v = 2047;
    if (v < -2048) v = -2048;
    return int'(v);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference update at the clock edge, from inputs driven on the falling edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_phase = 0; m_offs = 0; m_amp = 0;
      s_step = 0; s_phase = 0; s_offs = 0; s_amp = 0;
      m_run = 0; m_fill = 0; m_k = 0;
    end else begin
      if (!run_en) begin
        m_run = 0; m_fill = 0;
      end else if (!m_run) begin
        m_run = 1; m_fill = 0; m_k = 0;
        s_step = m_step; s_phase = m_phase; s_offs = m_offs; s_amp = m_amp;
      end else begin
        if (m_fill == 3 && smp_ready) m_k++;
        if (!(m_fill == 3 && !smp_ready) && m_fill < 3) m_fill++;
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_step  = int'(cfg_wdata & 32'h3FFF_FFFF);
          2'd1: m_phase = int'(cfg_wdata & 32'h000F_FFFF);
          2'd2: m_offs  = int'(cfg_wdata & 32'h0000_0FFF);
          default: m_amp = int'(cfg_wdata & 32'h0000_07FF);
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = m_run && (m_fill == 3);
      check(smp_valid == ev, "R8", "valid", int'(smp_valid), int'(ev));
      if (ev && smp_valid) begin
        int e;
        e = exp_sample(m_k, s_step, s_phase, s_offs, s_amp);
        check(sx12(int'(smp_data)) == e, tag, "sample", sx12(int'(smp_data)), e);
      end else if (!ev && !smp_valid) begin
        check(sx12(int'(smp_data)) == sx12(m_offs), "R10", "idle data",
              sx12(int'(smp_data)), sx12(m_offs));
      end
    end
  end

  always @(negedge clk) smp_ready <= bp_mode ? (($urandom % 3) != 0) : 1'b1;

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[1:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(int a, int e, string req);
    cfg_addr = a[1:0];
    #1;
    check(cfg_rdata == 32'(e), req, "readback", int'(cfg_rdata), e);
  endtask

  task automatic cfg4(int st, int ph, int of, int am);
    wr(0, 32'(st)); wr(1, 32'(ph)); wr(2, 32'(of)); wr(3, 32'(am));
  endtask

  task automatic run(int n, string t);
    tag = t;
    @(negedge clk);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic stop();
    @(negedge clk);
    run_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and field masking on readback
    for (int a = 0; a < 4; a++) rd_chk(a, 0, "R1");
    for (int a = 0; a < 4; a++) wr(a, 32'hFFFF_FFFF);
    rd_chk(0, 32'h3FFF_FFFF, "R1");
    rd_chk(1, 32'h000F_FFFF, "R1");
    rd_chk(2, 32'h0000_0FFF, "R1");
    rd_chk(3, 32'h0000_07FF, "R1");
    @(negedge clk);
    // R2: step of all ones runs the phase backwards through the wrap
    run(120, "R2");
    stop();
    // R4: irregular step, full amplitude, all quadrants
    cfg4(32'h0123_4567, 0, 0, 2047);
    run(200, "R4");
    stop();
    // R3: 45 degree phase offset
    cfg4(32'h0010_0000, 32'h2_0000, 0, 2047);
    run(80, "R3");
    stop();
    // R11: zero step gives a constant
    cfg4(0, 32'h1_2345, 32'hED4, 1000);
    run(40, "R11");
    stop();
    // R5: mid amplitude plus offset, then zero amplitude
    cfg4(32'h0234_5678, 0, 100, 1234);
    run(100, "R5");
    stop();
    wr(3, 0);
    run(30, "R5");
    stop();
    // R6: clamp at both rails
    cfg4(32'h0300_0000, 0, 32'h7FF, 2047);
    run(60, "R6");
    stop();
    wr(2, 32'h800);
    run(60, "R6");
    stop();
    // R9: random back-pressure
    cfg4(32'h0234_5678, 32'h0_4000, 32'hFC0, 1800);
    bp_mode = 1'b1;
    run(400, "R9");
    stop();
    bp_mode = 1'b0;
    // R7: writes while running are ignored; R10 then R2 on restart
    cfg4(32'h0111_1111, 0, 0, 1500);
    run(20, "R7");
    cfg4(32'h0222_2222, 32'h8_0000, 32'h050, 700);
    repeat (60) @(negedge clk);
    stop();
    run(80, "R2");
    stop();
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule